// File: doc/BRIEF.md
# Double-Buffered Parameter Register Bank

This block holds a small set of slowly changing settings, such as values that apply to a whole video frame, and hands them from a control writer to hardware processing units. These settings are not tokens, so no handshake runs between writer and consumer. Each setting has two copies. The writer loads a staging copy one register at a time, whenever it likes. The consumer sees only the live copy.

A single update pulse moves every staging value into the live copies on the same clock edge. The consumer therefore never observes a half-changed parameter set. A valid flag rises with the first update and tells the consumer that the live values carry real settings rather than their reset zeros.

A combinational read port lets either copy be inspected by index. The writer typically loads the staging registers during a frame, then pulses update at the frame boundary.

Top module: `shadow_param_bank`

## Requirements
- R1: While the internal reset is active, and until the first update, every live register reads zero and `cfg_valid` is 0. The internal reset asserts asynchronously with `rst_n` low and releases on the second rising clock edge after `rst_n` goes high.
- R2: A write with `wr_en`=1 and an in-range `wr_addr` loads `wr_data` into that index's staging register at the clock edge. No other staging register changes.
- R3: Without `update`, the live registers (`cfg_flat` and reads with `rd_bank`=0) keep their values across any number of staging writes.
- R4: When `update` is 1 at a clock edge, every live register takes its staging value at that edge. The whole bank changes in one cycle.
- R5: A staging write in the same cycle as `update` is included in that update: the live register receives the new `wr_data`.
- R6: `cfg_valid` becomes 1 at the first update edge after reset. It then stays 1 until reset.
- R7: Writes with `wr_addr` >= `NREGS` change no register. Reads with `rd_addr` >= `NREGS` return zero.
- R8: `rd_data` combinationally returns the selected register: staging copy when `rd_bank`=1, live copy when `rd_bank`=0.
- R9: Register index i occupies bits [i*W +: W] of `cfg_flat`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Staging write enable |
| wr_addr | input | AW | Staging register index |
| wr_data | input | W | Staging write value |
| update | input | 1 | Copy all staging registers to live registers |
| rd_bank | input | 1 | Read select: 0 live, 1 staging |
| rd_addr | input | AW | Read index |
| rd_data | output | W | Selected register value |
| cfg_flat | output | NREGS*W | All live registers, index i at bits [i*W +: W] |
| cfg_valid | output | 1 | Live registers hold updated settings |

## Verification
The assertions check on every cycle that the live bank holds still without an update, that valid rises with an update and never falls, that the live bank is zero while valid is low, that a write colliding with an update reaches the live copy, and that out-of-range reads return zero. The bench's reference model compares every port on every clock. Only its scenarios show that each staging write hits exactly one index, that all registers change together, and the reset release timing. The same holds for the exact contents seen through both read banks.

// File: rtl/spb_pkg.sv
package spb_pkg;
  typedef enum logic {
    BANK_LIVE  = 1'b0,
    BANK_STAGE = 1'b1
  } bank_sel_e;
endpackage

// File: rtl/spb_rst_sync.sv
module spb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/spb_stage_bank.sv
module spb_stage_bank #(
  parameter int NREGS = 6,
  parameter int W     = 16,
  parameter int AW    = 3
) (
  input  logic                      clk,
  input  logic                      rst_core_n,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_addr,
  input  logic [W-1:0]              wr_data,
  output logic [NREGS-1:0][W-1:0]   stage_q,
  output logic [NREGS-1:0][W-1:0]   stage_d
);
  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    logic hit;
    always_comb begin
      hit        = wr_en && (wr_addr == AW'(i));
      stage_d[i] = hit ? wr_data : stage_q[i];
    end
    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n)  stage_q[i] <= '0;
      else if (hit)     stage_q[i] <= stage_d[i];
    end
  end
endmodule

// File: rtl/spb_live_bank.sv
module spb_live_bank #(
  parameter int NREGS = 6,
  parameter int W     = 16
) (
  input  logic                      clk,
  input  logic                      rst_core_n,
  input  logic                      update,
  input  logic [NREGS-1:0][W-1:0]   stage_d,
  output logic [NREGS-1:0][W-1:0]   live_q,
  output logic                      valid_q
);
  logic [NREGS-1:0][W-1:0] live_d;
  logic                    valid_d;

  always_comb begin
    live_d  = update ? stage_d : live_q;
    valid_d = valid_q | update;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  live_q <= '0;
    else if (update)  live_q <= live_d;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) valid_q <= 1'b0;
    else             valid_q <= valid_d;
  end
endmodule

// File: rtl/spb_read_mux.sv
module spb_read_mux
  import spb_pkg::*;
#(
  parameter int NREGS = 6,
  parameter int W     = 16,
  parameter int AW    = 3
) (
  input  bank_sel_e                 sel,
  input  logic [AW-1:0]             rd_addr,
  input  logic [NREGS-1:0][W-1:0]   stage_q,
  input  logic [NREGS-1:0][W-1:0]   live_q,
  output logic [W-1:0]              rd_data
);
  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (rd_addr == AW'(i)) begin
        rd_data = (sel == BANK_STAGE) ? stage_q[i] : live_q[i];
      end
    end
  end
endmodule

// File: rtl/shadow_param_bank.sv
module shadow_param_bank
  import spb_pkg::*;
#(
  parameter int NREGS = 6,
  parameter int W     = 16,
  parameter int AW    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [W-1:0]       wr_data,
  input  logic               update,
  input  logic               rd_bank,
  input  logic [AW-1:0]      rd_addr,
  output logic [W-1:0]       rd_data,
  output logic [NREGS*W-1:0] cfg_flat,
  output logic               cfg_valid
);
  logic                    rst_core_n;
  logic [NREGS-1:0][W-1:0] stage_q;
  logic [NREGS-1:0][W-1:0] stage_d;
  logic [NREGS-1:0][W-1:0] live_q;
  bank_sel_e               sel;

  spb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_core_n(rst_core_n)
  );

  spb_stage_bank #(.NREGS(NREGS), .W(W), .AW(AW)) u_stage (
    .clk(clk), .rst_core_n(rst_core_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .stage_q(stage_q), .stage_d(stage_d)
  );

  spb_live_bank #(.NREGS(NREGS), .W(W)) u_live (
    .clk(clk), .rst_core_n(rst_core_n), .update(update),
    .stage_d(stage_d), .live_q(live_q), .valid_q(cfg_valid)
  );

  assign sel = bank_sel_e'(rd_bank);

  spb_read_mux #(.NREGS(NREGS), .W(W), .AW(AW)) u_rd (
    .sel(sel), .rd_addr(rd_addr), .stage_q(stage_q),
    .live_q(live_q), .rd_data(rd_data)
  );

  assign cfg_flat = live_q;
endmodule

// File: rtl/shadow_param_bank_chk.sv
module shadow_param_bank_chk #(
  parameter int NREGS = 6,
  parameter int W     = 16,
  parameter int AW    = 3
) (
  input logic               clk,
  input logic               rst_core_n,
  input logic               wr_en,
  input logic [AW-1:0]      wr_addr,
  input logic [W-1:0]       wr_data,
  input logic               update,
  input logic               rd_bank,
  input logic [AW-1:0]      rd_addr,
  input logic [W-1:0]       rd_data,
  input logic [NREGS*W-1:0] cfg_flat,
  input logic               cfg_valid
);
  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_core_n)
    !update |=> $stable(cfg_flat)); // R3
  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_core_n)
    update |=> cfg_valid); // R6
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_core_n)
    cfg_valid |=> cfg_valid); // R6
  AST_ZERO_BEFORE_VALID: assert property (@(posedge clk) disable iff (!rst_core_n)
    !cfg_valid |-> (cfg_flat == '0)); // R1
  AST_COLLIDE_WRITE: assert property (@(posedge clk) disable iff (!rst_core_n)
    (update && wr_en && wr_addr == '0) |=> (cfg_flat[W-1:0] == $past(wr_data))); // R5
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    (rd_addr >= AW'(NREGS)) |-> (rd_data == '0)); // R7
  AST_LIVE_READ: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!rd_bank && rd_addr == '0) |-> (rd_data == cfg_flat[W-1:0])); // R8
endmodule

bind shadow_param_bank shadow_param_bank_chk #(.NREGS(NREGS), .W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_core_n(rst_core_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .update(update), .rd_bank(rd_bank), .rd_addr(rd_addr),
  .rd_data(rd_data), .cfg_flat(cfg_flat), .cfg_valid(cfg_valid)
);

// File: tb/shadow_param_bank_tb.sv
`timescale 1ns/1ps
module shadow_param_bank_tb;
  localparam int NREGS = 6;
  localparam int W     = 16;
  localparam int AW    = 3;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               wr_en, update, rd_bank;
  logic [AW-1:0]      wr_addr, rd_addr;
  logic [W-1:0]       wr_data;
  logic [W-1:0]       rd_data;
  logic [NREGS*W-1:0] cfg_flat;
  logic               cfg_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [W-1:0] m_stage [NREGS];
  logic [W-1:0] m_live  [NREGS];
  bit           m_valid;

  always #4 clk = ~clk;

  shadow_param_bank #(.NREGS(NREGS), .W(W), .AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .update(update), .rd_bank(rd_bank),
    .rd_addr(rd_addr), .rd_data(rd_data), .cfg_flat(cfg_flat),
    .cfg_valid(cfg_valid)
  );

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    logic [W-1:0] exp_rd;
    exp_rd = '0;
    if (int'(rd_addr) < NREGS) exp_rd = rd_bank ? m_stage[rd_addr] : m_live[rd_addr];
    for (int i = 0; i < NREGS; i++) begin
      check(tag, $sformatf("R9 live[%0d]", i), cfg_flat[i*W +: W], m_live[i]);
    end
    check(tag, "R6 valid", W'(cfg_valid), W'(m_valid));
    check(tag, "R8 rd_data", rd_data, exp_rd);
  endtask

  // one cycle: drive at negedge, model at posedge, compare at next negedge
  task automatic step(string tag, bit we, int wa, logic [W-1:0] wd, bit up, bit rb, int ra);
    wr_en = we; wr_addr = AW'(wa); wr_data = wd; update = up;
    rd_bank = rb; rd_addr = AW'(ra);
    @(posedge clk);
    if (we && wa < NREGS) m_stage[wa] = wd;
    if (up) begin
      for (int i = 0; i < NREGS; i++) m_live[i] = m_stage[i];
      m_valid = 1;
    end
    @(negedge clk);
    compare_all(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREGS; i++) begin m_stage[i] = '0; m_live[i] = '0; end
    m_valid = 0;
    rst_n = 1'b0; wr_en = 0; wr_addr = '0; wr_data = '0; update = 0;
    rd_bank = 0; rd_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare_all("R1");
    // R1: idle cycles, nothing changes
    step("R1", 0, 0, 16'h0, 0, 0, 2);
    // R2: write every staging reg, read back staging
    for (int i = 0; i < NREGS; i++) step("R2", 1, i, W'(16'h1100 + i*16'h0101), 0, 1, i);
    // R3: live still zero, valid still low
    for (int i = 0; i < NREGS; i++) step("R3", 0, 0, 16'h0, 0, 0, i);
    // R4: update moves all at once
    step("R4", 0, 0, 16'h0, 1, 0, 3);
    for (int i = 0; i < NREGS; i++) step("R4", 0, 0, 16'h0, 0, 0, i);
    // R3: new staging writes do not disturb live
    step("R3", 1, 2, 16'hBEEF, 0, 0, 2);
    step("R3", 1, 4, 16'hCAFE, 0, 1, 4);
    step("R3", 0, 0, 16'h0, 0, 0, 4);
    // R5: write colliding with update is included
    step("R5", 1, 0, 16'hA5A5, 1, 0, 0);
    step("R5", 1, 5, 16'h5A5A, 1, 0, 5);
    step("R5", 0, 0, 16'h0, 0, 0, 2);
    // R7: out-of-range writes ignored, reads zero
    step("R7", 1, 6, 16'hFFFF, 0, 1, 6);
    step("R7", 1, 7, 16'hEEEE, 1, 0, 7);
    for (int i = 0; i < NREGS; i++) step("R7", 0, 0, 16'h0, 0, 1, i);
    // R6: valid sticky over idle and further updates
    step("R6", 0, 0, 16'h0, 0, 0, 1);
    step("R6", 0, 0, 16'h0, 1, 0, 1);
    // mixed pattern
    for (int k = 0; k < 40; k++)
      step("R8", (k % 3) != 0, k % 8, W'(k * 16'h0313 + 16'h0042), (k % 7) == 6, k[0], (k + 3) % 8);
    // R1: reset again clears everything
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < NREGS; i++) begin m_stage[i] = '0; m_live[i] = '0; end
    m_valid = 0;
    #1;
    compare_all("R1");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    step("R1", 0, 0, 16'h0, 0, 1, 3);
    step("R6", 0, 0, 16'h0, 1, 0, 3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule